// File: doc/BRIEF.md
# Hierarchical Powerdown Controller

This block turns the powerdown bits of a converter control register into active-high enable lines for one ADC, a configurable number of stereo DACs (three by default) and a shared reference block that all converters depend on. Each converter can be switched off by its own bit. The reference block stays powered for as long as the master powerdown bit is clear, even if every converter is off.

The master powerdown bit overrides every other bit. When it is set, the block drops all converter enables in the same cycle. It then holds the references up for a programmable settling window (`SETTLE_CYCLES`, default 16) before it removes them, so converters are never left running from a collapsing reference. When the master bit clears, the order is reversed: the references return first, and the converters rejoin only after the same window. A status flag reports that the references have actually been removed. Every port is a plain level signal and there is no data stream.

Top module: `pd_hier_ctrl`

## Requirements
- R1: While in normal operation (master bit clear, sequence complete), `adc_en` equals the inverse of `adc_pd`, and `adc_pd` has no effect on `dac_en` or `ref_en`.
- R2: While in normal operation, bit i of `dac_en` equals the inverse of bit i of `dac_pd` for each DAC, independently of the other bits.
- R3: With `adc_pd` and every `dac_pd` bit set but `master_pd` clear, all converter enables are low while `ref_en` stays high and `full_pd` stays low.
- R4: Whenever `master_pd` is high, `adc_en` and every `dac_en` bit are low in that same cycle, whatever the other bits hold.
- R5: Shutdown: counting the first rising edge that samples `master_pd` high as edge 1, `ref_en` stays high through edge `SETTLE_CYCLES` and goes low at edge `SETTLE_CYCLES`+1.
- R6: Wake-up: `ref_en` rises at the first edge that samples `master_pd` low. Converter enables stay low through edge `SETTLE_CYCLES` and follow their own bits from edge `SETTLE_CYCLES`+1.
- R7: `full_pd` is high exactly when `ref_en` is low. No converter enable is ever high while `ref_en` is low.
- R8: During and after reset the block is fully powered down: all enables are low and `full_pd` is high. It leaves that state only through the R6 wake-up sequence.
- R9: If `master_pd` clears during the shutdown window, the next edge returns to normal operation with the references never removed. If `master_pd` sets during the wake-up window, the next edge removes the references.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_pd | input | 1 | ADC powerdown request |
| dac_pd | input | NUM_DAC | Per-stereo-DAC powerdown requests |
| master_pd | input | 1 | Master powerdown, overrides all others |
| adc_en | output | 1 | ADC enable, active high |
| dac_en | output | NUM_DAC | Stereo DAC enables, active high |
| ref_en | output | 1 | Shared reference enable, active high |
| full_pd | output | 1 | References removed, everything off |

## Verification
The hardest situations to reach are the abort paths, where `master_pd` reverses partway through a settling window. There the block must either keep the references it was about to drop or drop the references it has only just restored. The bench reaches every point of both windows. For each offset it starts a fresh shutdown or wake-up, counts edges to the chosen point, flips `master_pd`, and checks the outputs at the next edge. It also crosses all sixteen ADC/DAC bit patterns with the full shutdown and wake-up timing.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_DRAIN = 2'd1,
    PD_OFF   = 2'd2,
    PD_WAKE  = 2'd3
  } pd_state_t;
endpackage

// File: rtl/pd_settle_timer.sv
module pd_settle_timer #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // R5/R6: the window counter never runs past its final count
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6: every new window starts from zero
  assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_pd,
  output logic conv_ok,
  output logic ref_en,
  output logic full_pd
);
  pd_state_t state_q, state_d;
  logic      win_run, win_done;

  assign win_run = (state_q == PD_DRAIN) || (state_q == PD_WAKE);

  pd_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (win_run),
    .done (win_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PD_RUN:   if (master_pd) state_d = PD_DRAIN;
      PD_DRAIN: if (!master_pd)    state_d = PD_RUN;
                else if (win_done) state_d = PD_OFF;
      PD_OFF:   if (!master_pd) state_d = PD_WAKE;
      PD_WAKE:  if (master_pd)     state_d = PD_OFF;
                else if (win_done) state_d = PD_RUN;
      default:  state_d = PD_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PD_OFF;
    else        state_q <= state_d;
  end

  assign conv_ok = (state_q == PD_RUN) && !master_pd;
  assign ref_en  = (state_q != PD_OFF);
  assign full_pd = (state_q == PD_OFF);

  // R5: references only drop after the master bit was seen high
  assert_ref_drop_needs_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_en) |-> $past(master_pd));
  // R6: references only return after the master bit was seen low
  assert_ref_rise_needs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> !$past(master_pd));
  // R9: a drain that is aborted never passes through the off state
  assert_drain_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_DRAIN && !master_pd) |=> ref_en);
endmodule

// File: rtl/pd_enable_gate.sv
module pd_enable_gate #(
  parameter int NUM_DAC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_ok,
  input  logic               adc_pd,
  input  logic [NUM_DAC-1:0] dac_pd,
  output logic               adc_en,
  output logic [NUM_DAC-1:0] dac_en
);
  assign adc_en = conv_ok && !adc_pd;

  for (genvar g = 0; g < NUM_DAC; g++) begin : g_dac
    assign dac_en[g] = conv_ok && !dac_pd[g];
  end

  // R4/R7: a withheld permission silences every converter
  assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_ok |-> (!adc_en && dac_en == '0));
endmodule

// File: rtl/pd_hier_ctrl.sv
module pd_hier_ctrl #(
  parameter int NUM_DAC       = 3,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adc_pd,
  input  logic [NUM_DAC-1:0] dac_pd,
  input  logic               master_pd,
  output logic               adc_en,
  output logic [NUM_DAC-1:0] dac_en,
  output logic               ref_en,
  output logic               full_pd
);
  logic conv_ok;

  pd_sequencer #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_pd(master_pd),
    .conv_ok  (conv_ok),
    .ref_en   (ref_en),
    .full_pd  (full_pd)
  );

  pd_enable_gate #(.NUM_DAC(NUM_DAC)) i_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .conv_ok(conv_ok),
    .adc_pd (adc_pd),
    .dac_pd (dac_pd),
    .adc_en (adc_en),
    .dac_en (dac_en)
  );

  // R4: the master bit silences all converters in the same cycle
  assert_master_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
    master_pd |-> (!adc_en && dac_en == '0));
  // R7: no converter runs without references
  assert_conv_needs_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en || dac_en != '0) |-> ref_en);
  // R7: status flag tracks reference removal
  assert_flag_matches_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_pd == !ref_en);
endmodule

// File: tb/test_pd_hier_ctrl.sv
module test_pd_hier_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NDAC = 3;
  localparam int DLY  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_pd = 1'b0;
  logic [NDAC-1:0] dac_pd = '0;
  logic master_pd = 1'b1;
  logic adc_en, ref_en, full_pd;
  logic [NDAC-1:0] dac_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_hier_ctrl #(.NUM_DAC(NDAC), .SETTLE_CYCLES(DLY)) i_pd_hier_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_pd(adc_pd), .dac_pd(dac_pd),
    .master_pd(master_pd), .adc_en(adc_en), .dac_en(dac_en),
    .ref_en(ref_en), .full_pd(full_pd)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // packed view: {full_pd, ref_en, adc_en, dac_en}
  function automatic logic [5:0] outs();
    return {full_pd, ref_en, adc_en, dac_en};
  endfunction

  function automatic logic [5:0] exp_run(logic a, logic [NDAC-1:0] d);
    return {1'b0, 1'b1, ~a, ~d};
  endfunction

  localparam logic [5:0] EXP_OFF  = 6'b10_0_000;
  localparam logic [5:0] EXP_HOLD = 6'b01_0_000;

  task automatic chk(string req, logic [5:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: act=%b exp=%b", req, outs(), exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  // from off: release master and walk the wake window (R6)
  task automatic wake_up(bit verify);
    master_pd = 1'b0;
    #1;
    if (verify) chk("R6 still off before edge", EXP_OFF);
    for (int e = 1; e <= DLY + 1; e++) begin
      tick();
      if (verify) begin
        if (e <= DLY) chk("R6 refs first", EXP_HOLD);
        else          chk("R6 converters rejoin", exp_run(adc_pd, dac_pd));
      end
    end
  endtask

  // from run: raise master and walk the drain window (R4, R5)
  task automatic shut_down(bit verify);
    master_pd = 1'b1;
    #1;
    if (verify) chk("R4 same-cycle override", EXP_HOLD);
    for (int e = 1; e <= DLY + 1; e++) begin
      tick();
      if (verify) begin
        if (e <= DLY) chk("R5 refs held in drain", EXP_HOLD);
        else          chk("R5 refs removed", EXP_OFF);
      end
    end
  endtask

  initial begin
    // R8: reset state
    #(CLK_PERIOD*2 + 1);
    chk("R8 in reset", EXP_OFF);
    tick();
    rst_n = 1'b1;
    tick(); tick();
    chk("R8 stays off with master set", EXP_OFF);
    wake_up(1'b1);

    // R1, R2, R3: sweep every converter bit pattern in normal operation
    for (int p = 0; p < 16; p++) begin
      adc_pd = p[3];
      dac_pd = p[2:0];
      #1;
      if (p == 15) chk("R3 refs kept with all converters off", exp_run(1'b1, 3'b111));
      else chk("R1 R2 per-unit enables", exp_run(adc_pd, dac_pd));
      tick();
      chk("R1 R2 stable after edge", exp_run(adc_pd, dac_pd));
    end

    // R4, R5, R6, R7: full cycles for every bit pattern
    for (int p = 0; p < 16; p++) begin
      adc_pd = p[3];
      dac_pd = p[2:0];
      shut_down(1'b1);
      adc_pd = ~adc_pd;
      dac_pd = ~dac_pd;
      #1;
      chk("R4 bits ignored while off", EXP_OFF);
      adc_pd = p[3];
      dac_pd = p[2:0];
      wake_up(1'b1);
    end

    // R9: abort the drain at every offset
    adc_pd = 1'b0;
    dac_pd = 3'b010;
    for (int j = 1; j <= DLY; j++) begin
      master_pd = 1'b1;
      for (int e = 0; e < j; e++) tick();
      chk("R9 in drain before abort", EXP_HOLD);
      master_pd = 1'b0;
      #1;
      chk("R9 held until edge", EXP_HOLD);
      tick();
      chk("R9 drain abort returns to run", exp_run(1'b0, 3'b010));
    end

    // R9: abort the wake at every offset
    shut_down(1'b0);
    for (int j = 1; j <= DLY; j++) begin
      master_pd = 1'b0;
      for (int e = 0; e < j; e++) tick();
      chk("R9 in wake before abort", EXP_HOLD);
      master_pd = 1'b1;
      tick();
      chk("R9 wake abort removes refs", EXP_OFF);
    end

    // R8: reset from run drops everything at once
    wake_up(1'b0);
    chk("R8 back in run", exp_run(1'b0, 3'b010));
    rst_n = 1'b0;
    #1;
    chk("R8 async reset", EXP_OFF);
    tick();
    rst_n = 1'b1;
    master_pd = 1'b0;
    tick();
    chk("R8 leaves reset via wake", EXP_HOLD);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule